// File: doc/BRIEF.md
# Logical Wire Packet Bridge

This block carries a bundle of eight single-bit signals from one tile to another across a packet network. Nothing is wired between the tiles. The sending half samples the local wire bundle. Whenever the sampled value differs from the value it last handed to the network, it offers a 16-bit packet on a valid/ready injection port. The receiving half watches packets arriving from the network. When a packet carries the logical-wire tag, the receiving half loads the packet's wire field into a registered 8-bit output.

Each packet has two fields. The low byte holds the wire state. The high byte holds a fixed tag, set by a parameter, that marks the packet as a logical-wire packet. If the network stalls the sender and the wires keep moving, the pending packet is rewritten with the newest sample. Only the latest state reaches the far tile, and the packet rate is never higher than the rate of change of the wires. The two halves share a clock and reset but are otherwise independent, so one instance can serve as either end of a link, or as both.

Top module: `lwire_bridge`

## Requirements
- R1: After a synchronous active-high reset, `tx_valid` is 0, `wires_out` is 0 and the remembered last-sent state is 0. While `wires_in` stays 0, no packet is offered.
- R2: With the default single sampling stage, a change on `wires_in` that is applied before clock edge k raises `tx_valid` after edge k+1 (two edges later), provided no packet was pending.
- R3: An offered packet carries the tag parameter (default 8'hA5) in `tx_data[15:8]` and the sampled wire values in `tx_data[7:0]`.
- R4: While the sampled wires equal the last accepted state and nothing is pending, `tx_valid` stays 0.
- R5: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1. The payload stays the same as long as the wires do not change.
- R6: If the wires change during a stall, the pending payload is replaced by the newest sample. Intermediate values are never sent once superseded.
- R7: The edge on which `tx_valid` and `tx_ready` are both 1 transfers the packet. If the wires equal the transferred value, `tx_valid` is 0 after that edge.
- R8: A packet with `rx_valid` 1 and `rx_data[15:8]` equal to the tag sets `wires_out` to `rx_data[7:0]` one edge later.
- R9: A packet whose `rx_data[15:8]` differs from the tag leaves `wires_out` unchanged.
- R10: While `rx_valid` is 0, `wires_out` holds its value whatever `rx_data` carries.
- R11: If the sampled wires differ from a packet on the edge that transfers it, `tx_valid` stays 1 and the new value is offered at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| wires_in | input | 8 | Local wire bundle to forward |
| tx_valid | output | 1 | Packet offered to the network |
| tx_ready | input | 1 | Network accepts the offered packet |
| tx_data | output | 16 | Offered packet: tag in [15:8], wires in [7:0] |
| rx_valid | input | 1 | Incoming packet present |
| rx_data | input | 16 | Incoming packet: tag in [15:8], wires in [7:0] |
| wires_out | output | 8 | Registered copy of the remote wire bundle |

## Verification
Send results pass through two registers. A wire change shows on `tx_valid` and `tx_data` two edges after it is applied. A rewrite during a stall shows two edges later as well. A transfer changes `tx_valid` one edge after the accepting edge. Receive results pass through one register, so `wires_out` moves one edge after a tagged packet. The bench drives inputs on falling edges and advances an exact number of rising edges before it samples on the next falling edge. It also checks the intermediate edge, which confirms that a result does not appear early.

// File: rtl/lw_pkg.sv
package lw_pkg;

    localparam int WIRE_W = 8;
    localparam int TAG_W  = 8;
    localparam int PKT_W  = WIRE_W + TAG_W;
    localparam logic [TAG_W-1:0] DEF_TAG = 8'hA5;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [WIRE_W-1:0] wires;
    } lw_pkt_t;

    function automatic lw_pkt_t lw_pack(input logic [TAG_W-1:0] tag,
                                        input logic [WIRE_W-1:0] w);
        lw_pkt_t p;
        p.tag   = tag;
        p.wires = w;
        return p;
    endfunction

    function automatic logic lw_tag_hit(input lw_pkt_t p,
                                        input logic [TAG_W-1:0] tag);
        return p.tag == tag;
    endfunction

endpackage

// File: rtl/lw_sampler.sv
module lw_sampler
    import lw_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIRE_W-1:0] wires_in,
    output logic [WIRE_W-1:0] samp
);

    logic [WIRE_W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= wires_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign samp = chain[STAGES-1];

endmodule

// File: rtl/lw_tx_slot.sv
module lw_tx_slot
    import lw_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG = DEF_TAG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIRE_W-1:0] samp,
    input  logic              tx_ready,
    output logic              tx_valid,
    output lw_pkt_t           tx_pkt
);

    logic              valid_q;
    logic [WIRE_W-1:0] wires_q;
    logic [WIRE_W-1:0] last_q;
    logic              accept;
    logic              stall;
    logic [WIRE_W-1:0] ref_w;
    logic              diff;

    always_comb begin
        accept = valid_q & tx_ready;
        stall  = valid_q & ~tx_ready;
        ref_w  = accept ? wires_q : last_q;
        diff   = (samp != ref_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            wires_q <= '0;
            last_q  <= '0;
        end else begin
            if (accept) last_q <= wires_q;
            if (stall) begin
                wires_q <= samp;
            end else begin
                valid_q <= diff;
                if (diff) wires_q <= samp;
            end
        end
    end

    assign tx_valid = valid_q;
    assign tx_pkt   = lw_pack(TAG, wires_q);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !tx_ready) |=> valid_q); // R5

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !tx_ready && wires_q == samp) |=> $stable(wires_q)); // R5

    AST_STALL_LATEST: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !tx_ready) |=> (wires_q == $past(samp))); // R6

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && samp == last_q) |=> !valid_q); // R4

endmodule

// File: rtl/lw_rx_decode.sv
module lw_rx_decode
    import lw_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG = DEF_TAG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  lw_pkt_t           rx_pkt,
    output logic [WIRE_W-1:0] wires_out
);

    logic              hit;
    logic [WIRE_W-1:0] out_q;

    assign hit = rx_valid & lw_tag_hit(rx_pkt, TAG);

    always_ff @(posedge clk) begin
        if (rst)      out_q <= '0;
        else if (hit) out_q <= rx_pkt.wires;
    end

    assign wires_out = out_q;

    AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_pkt.tag == TAG) |=> (out_q == $past(rx_pkt.wires))); // R8

    AST_RX_FOREIGN: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_pkt.tag != TAG) |=> $stable(out_q)); // R9

    AST_RX_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(out_q)); // R10

endmodule

// File: rtl/lwire_bridge.sv
module lwire_bridge
    import lw_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG         = DEF_TAG,
    parameter int               SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIRE_W-1:0] wires_in,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [PKT_W-1:0]  tx_data,
    input  logic              rx_valid,
    input  logic [PKT_W-1:0]  rx_data,
    output logic [WIRE_W-1:0] wires_out
);

    logic [WIRE_W-1:0] samp;
    lw_pkt_t           tx_pkt;
    lw_pkt_t           rx_pkt;

    lw_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk      (clk),
        .rst      (rst),
        .wires_in (wires_in),
        .samp     (samp)
    );

    lw_tx_slot #(.TAG(TAG)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .samp     (samp),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_pkt   (tx_pkt)
    );

    assign tx_data = tx_pkt;
    assign rx_pkt  = rx_data;

    lw_rx_decode #(.TAG(TAG)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_pkt    (rx_pkt),
        .wires_out (wires_out)
    );

    AST_TX_TAG: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_data[PKT_W-1:WIRE_W] == TAG)); // R3

endmodule

// File: tb/lwire_bridge_test.sv
module lwire_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  wires_in;
    logic        tx_valid;
    logic        tx_ready;
    logic [15:0] tx_data;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic [7:0]  wires_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    lwire_bridge uut (
        .clk       (clk),
        .rst       (rst),
        .wires_in  (wires_in),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .wires_out (wires_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; wires_in = 8'h00; tx_ready = 1'b0;
        rx_valid = 1'b0; rx_data = 16'h0000;
        step(3);
        rst = 1'b0;
        check("R1 tx_valid after reset", {15'd0, tx_valid}, 16'd0);
        check("R1 wires_out after reset", {8'd0, wires_out}, 16'd0);
        step(4);
        check("R1 no packet before first change", {15'd0, tx_valid}, 16'd0);
    endtask

    task automatic t_send_stall();
        wires_in = 8'h3C;
        step(1);
        check("R2 not yet valid after one edge", {15'd0, tx_valid}, 16'd0);
        step(1);
        check("R2 valid two edges after change", {15'd0, tx_valid}, 16'd1);
        check("R3 packet tag and wires", tx_data, 16'hA53C);
        step(3);
        check("R5 valid held while stalled", {15'd0, tx_valid}, 16'd1);
        check("R5 payload held while stalled", tx_data, 16'hA53C);
        tx_ready = 1'b1;
        step(1);
        check("R7 valid drops after transfer", {15'd0, tx_valid}, 16'd0);
        step(3);
        check("R4 no resend of unchanged state", {15'd0, tx_valid}, 16'd0);
        tx_ready = 1'b0;
    endtask

    task automatic t_coalesce();
        wires_in = 8'h11;
        step(2);
        check("R3 packet for 11", tx_data, 16'hA511);
        wires_in = 8'h22;
        step(2);
        check("R6 pending rewritten to 22", tx_data, 16'hA522);
        wires_in = 8'h33;
        step(2);
        check("R6 pending rewritten to 33", tx_data, 16'hA533);
        check("R5 still valid", {15'd0, tx_valid}, 16'd1);
        tx_ready = 1'b1;
        step(1);
        check("R6 only latest sent, then idle", {15'd0, tx_valid}, 16'd0);
        tx_ready = 1'b0;
    endtask

    task automatic t_back_to_back();
        wires_in = 8'h40;
        step(2);
        check("R2 packet for 40", tx_data, 16'hA540);
        wires_in = 8'h41;
        step(1);
        tx_ready = 1'b1;
        step(1);
        check("R11 valid kept on transfer with new change", {15'd0, tx_valid}, 16'd1);
        check("R11 new value offered", tx_data, 16'hA541);
        step(1);
        check("R7 idle after second transfer", {15'd0, tx_valid}, 16'd0);
        tx_ready = 1'b0;
        wires_in = 8'h00;
        step(2);
        check("R3 change back to zero sent", tx_data, 16'hA500);
        tx_ready = 1'b1;
        step(1);
        tx_ready = 1'b0;
    endtask

    task automatic t_receive();
        rx_valid = 1'b1; rx_data = 16'hA55A;
        step(1);
        rx_valid = 1'b0;
        check("R8 tagged packet loads output", {8'd0, wires_out}, 16'h005A);
        rx_valid = 1'b1; rx_data = 16'h1234;
        step(1);
        check("R9 foreign tag 12 ignored", {8'd0, wires_out}, 16'h005A);
        rx_data = 16'hA4FF;
        step(1);
        check("R9 foreign tag A4 ignored", {8'd0, wires_out}, 16'h005A);
        rx_valid = 1'b0; rx_data = 16'hA5FF;
        step(3);
        check("R10 output held without rx_valid", {8'd0, wires_out}, 16'h005A);
        rx_valid = 1'b1; rx_data = 16'hA5C3;
        step(1);
        rx_data = 16'hA500;
        check("R8 second load", {8'd0, wires_out}, 16'h00C3);
        step(1);
        rx_valid = 1'b0;
        check("R8 load of zero", {8'd0, wires_out}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_send_stall();
        t_coalesce();
        t_back_to_back();
        t_receive();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule